// File: doc/BRIEF.md
# Hash Message Write-Port Formatter

This block sits between the data write port of a hash engine and its digest core. Message data arrives as 32-bit writes, either as single processor stores or as DMA bursts of four words. Each word has its byte lanes permuted according to a 2-bit byte-order code. It is then counted against a programmed message length and passed to the core as a word stream. Each output word carries a valid byte count and an end-of-message marker.

The write port has no byte-enable mask, so the programmed length alone decides how many bytes of the final word are message data. The surplus lanes of the final word are forced to zero and excluded from the byte count. A control write loads the byte-order code and the bit length, and data is then held off for a fixed settling gap. A write that arrives before any configuration, or after the message has been fully consumed, is swallowed and raises a sticky error flag. The core side uses a valid/ready handshake, and a stalled core stalls the write port.

Top module: `msg_wport_fmt`

## Requirements
- R1: After reset `out_valid` and `wr_err` are 0, and `wr_ready` is 1 because the unconfigured port swallows writes.
- R2: Output lane k is `out_data[8k+7:8k]`, and lane 0 is the first message byte. Order code 0 copies input lane k to output lane k. Code 1 takes output lane k from input lane 3-k.
- R3: Order code 2 swaps input lanes 3 and 2 and keeps lanes 1 and 0 in place. Code 3 swaps the upper 16-bit half with the lower half.
- R4: The message byte count is `cfg_bitlen >> 3`. Each output word reports `out_nbytes` = min(remaining, 4) with a value from 1 to 4. `out_last` is 1 exactly on the word that exhausts the count.
- R5: In the final word, the lanes at and above `out_nbytes` are driven to zero.
- R6: A control write sampled at clock edge E0 holds `wr_ready` low in the two cycles that follow E0. It goes high after edge E0+2, so the earliest accepted word is at E0+3.
- R7: A write made before any control write is consumed without producing output, and it sets `wr_err` at the same edge.
- R8: A write made after the last word of the message is consumed without producing output, and it sets `wr_err`.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output word stays stable and `wr_ready` is 0.
- R10: With `out_ready` held high, four back-to-back words are accepted on four consecutive clock edges.
- R11: A control write clears `wr_err` and restarts the byte count for a new message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control write strobe; loads order and length |
| cfg_order | input | 2 | Byte-order code |
| cfg_bitlen | input | LEN_W | Message length in bits |
| wr_valid | input | 1 | Write-port data valid |
| wr_data | input | 32 | Write-port data word |
| wr_ready | output | 1 | Write-port accept |
| out_valid | output | 1 | Word to core valid |
| out_ready | input | 1 | Core ready |
| out_data | output | 32 | Reordered, masked word |
| out_nbytes | output | 3 | Valid bytes in word (1..4) |
| out_last | output | 1 | Final word of message |
| wr_err | output | 1 | Sticky write-error flag |

## Verification
All four order codes are driven with words that have a distinct value in every byte, so any wrong lane selection shows up as a mismatch. Message lengths of 10, 16, 7 and 8 bytes place the message end after a final word of two bytes, after a full word, after three bytes, and inside a stalled transfer. These cases separate a correct tail count and tail mask from off-by-one errors. Writes before any configuration and after the message end check that swallowed words produce no output. A four-word burst with the core ready checks single-cycle acceptance, and a held `out_ready` checks that the stall reaches the write port.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_DONE   = 2'd3
  } fmt_state_e;

  // Permute byte lanes of one word according to the order code.
  function automatic logic [31:0] order_lanes(input logic [31:0] w, input logic [1:0] code);
    logic [31:0] r;
    case (code)
      2'd0:    r = w;
      2'd1:    r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      2'd2:    r = {w[23:16], w[31:24], w[15:0]};
      default: r = {w[15:0], w[31:16]};
    endcase
    return r;
  endfunction

  // Zero every lane at or above the valid byte count.
  function automatic logic [31:0] keep_lanes(input logic [31:0] w, input logic [2:0] n);
    logic [31:0] r;
    r = w;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) >= n) r[8*k +: 8] = 8'h00;
    end
    return r;
  endfunction

endpackage

// File: rtl/fmt_lane_swap.sv
module fmt_lane_swap
  import fmt_pkg::*;
(
  input  logic [31:0] in_word,
  input  logic [1:0]  order,
  input  logic [2:0]  nbytes,
  output logic [31:0] out_word
);
  logic [31:0] permuted;

  always_comb begin
    permuted = order_lanes(in_word, order);
    out_word = keep_lanes(permuted, nbytes);
  end
endmodule

// File: rtl/fmt_len_track.sv
module fmt_len_track
  import fmt_pkg::*;
#(
  parameter int LEN_W = 40,
  parameter int GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [LEN_W-1:0] cfg_bitlen,
  input  logic             take,
  output fmt_state_e       state,
  output logic [2:0]       cur_nbytes,
  output logic             cur_last
);
  localparam int CNT_W = LEN_W - 3;
  localparam int GAP_W = $clog2(GAP + 1);

  logic [CNT_W-1:0] rem;
  logic [GAP_W-1:0] gcnt;

  always_comb begin
    cur_last   = (rem <= CNT_W'(4));
    cur_nbytes = cur_last ? rem[2:0] : 3'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rem   <= '0;
      gcnt  <= '0;
    end else if (cfg_wr) begin
      state <= ST_SETTLE;
      rem   <= cfg_bitlen[LEN_W-1:3];
      gcnt  <= GAP_W'(GAP - 1);
    end else begin
      case (state)
        ST_SETTLE: begin
          if (gcnt == '0) state <= (rem == '0) ? ST_DONE : ST_RUN;
          else            gcnt  <= gcnt - 1'b1;
        end
        ST_RUN: begin
          if (take) begin
            rem <= rem - CNT_W'(cur_nbytes);
            if (cur_last) state <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R4: a word that exhausts the count ends the message
  assert_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_last) |=> (state == ST_DONE));

  // R6: data is only taken in the running state
  assert_take_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (state == ST_RUN));
endmodule

// File: rtl/msg_wport_fmt.sv
module msg_wport_fmt
  import fmt_pkg::*;
#(
  parameter int LEN_W = 40,
  parameter int GAP   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_order,
  input  logic [LEN_W-1:0] cfg_bitlen,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  output logic             wr_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic [2:0]       out_nbytes,
  output logic             out_last,
  output logic             wr_err
);
  fmt_state_e  state;
  logic [1:0]  order_q;
  logic [2:0]  cur_nbytes;
  logic        cur_last;
  logic [31:0] fmt_word;
  logic        room;
  logic        take;
  logic        discard;

  assign room    = !out_valid || out_ready;
  assign take    = (state == ST_RUN) && wr_valid && room && !cfg_wr;
  assign discard = ((state == ST_IDLE) || (state == ST_DONE)) && wr_valid && !cfg_wr;
  assign wr_ready = !cfg_wr && (((state == ST_RUN) && room) ||
                                (state == ST_IDLE) || (state == ST_DONE));

  fmt_len_track #(.LEN_W(LEN_W), .GAP(GAP)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_bitlen (cfg_bitlen),
    .take       (take),
    .state      (state),
    .cur_nbytes (cur_nbytes),
    .cur_last   (cur_last)
  );

  fmt_lane_swap u_swap (
    .in_word  (wr_data),
    .order    (order_q),
    .nbytes   (cur_nbytes),
    .out_word (fmt_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 2'd0;
      wr_err  <= 1'b0;
    end else if (cfg_wr) begin
      order_q <= cfg_order;
      wr_err  <= 1'b0;
    end else if (discard) begin
      wr_err  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_nbytes <= '0;
      out_last   <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_data   <= fmt_word;
      out_nbytes <= cur_nbytes;
      out_last   <= cur_last;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R6: no data taken within two edges of a control write
  assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (!$past(cfg_wr) && !$past(cfg_wr, 2)));

  // R9: a stalled word holds still
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_nbytes) && $stable(out_last)));

  // R4: byte count stays in 1..4, and a short word is always the last one
  assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_nbytes != 3'd0 && out_nbytes <= 3'd4 && (out_nbytes == 3'd4 || out_last)));

  // R5: the top lane of a short word is cleared
  assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nbytes < 3'd4) |-> (out_data[31:24] == 8'h00));

  // R7: a swallowed write raises the error flag
  assert_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> wr_err);
endmodule

// File: tb/sim_msg_wport_fmt.sv
`timescale 1ns/1ps
module sim_msg_wport_fmt;
  localparam int LEN_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_order = 2'd0;
  logic [LEN_W-1:0] cfg_bitlen = '0;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [31:0] out_data;
  logic [2:0] out_nbytes;
  logic out_last;
  logic wr_err;

  always #4 clk = ~clk;

  msg_wport_fmt #(.LEN_W(LEN_W), .GAP(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_order(cfg_order),
    .cfg_bitlen(cfg_bitlen), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_nbytes(out_nbytes), .out_last(out_last),
    .wr_err(wr_err)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int brem = 0;
  int bord = 0;
  int acc_cyc = 0;
  logic [35:0] expq[$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_word(input logic [31:0] w, input int code, input int n);
    logic [7:0] b[4];
    logic [31:0] r;
    int src;
    r = '0;
    for (int k = 0; k < 4; k++) b[k] = w[8*k +: 8];
    for (int k = 0; k < 4; k++) begin
      case (code)
        0: src = k;
        1: src = 3 - k;
        2: src = (k >= 2) ? 5 - k : k;
        default: src = k ^ 2;
      endcase
      if (k < n) r[8*k +: 8] = b[src];
    end
    return r;
  endfunction

  function automatic void push_exp(input logic [31:0] d);
    int n;
    if (brem > 0) begin
      n = (brem > 4) ? 4 : brem;
      expq.push_back({ref_word(d, bord, n), 3'(n), (brem <= 4)});
      brem -= n;
    end
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Monitor: pops and compares each transferred word
  initial begin
    logic [35:0] e;
    forever begin
      @(negedge clk);
      #2;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R7/R8 unexpected output word", {29'd0, out_data, out_nbytes}, 64'd0);
        end else begin
          e = expq.pop_front();
          check(out_data == e[35:4], "R2/R3/R5 out_data", out_data, e[35:4]);
          check(out_nbytes == e[3:1], "R4 out_nbytes", out_nbytes, e[3:1]);
          check(out_last == e[0], "R4 out_last", out_last, e[0]);
        end
      end
    end
  end

  task automatic configure(input int code, input int nbytes);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_order = 2'(code);
    cfg_bitlen = LEN_W'(nbytes * 8);
    wr_valid = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    bord = code;
    brem = nbytes;
    #2;
    check(wr_ready == 1'b0, "R6 ready low cycle 1", wr_ready, 0);
    check(wr_err == 1'b0, "R11 error cleared by control write", wr_err, 0);
    @(negedge clk); #2;
    check(wr_ready == 1'b0, "R6 ready low cycle 2", wr_ready, 0);
    @(negedge clk); #2;
    check(wr_ready == 1'b1, "R6 ready high after gap", wr_ready, 1);
  endtask

  task automatic send(input logic [31:0] d);
    bit ok;
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data = d;
    forever begin
      #2;
      ok = wr_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    acc_cyc = cyc;
    push_exp(d);
  endtask

  task automatic drop();
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    int c0;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    check(wr_err == 1'b0, "R1 reset wr_err", wr_err, 0);
    check(wr_ready == 1'b1, "R1 reset wr_ready", wr_ready, 1);

    // R7: write before configuration
    send(32'hDEADBEEF);
    drop();
    #2;
    check(wr_err == 1'b1, "R7 early write flags error", wr_err, 1);
    check(out_valid == 1'b0, "R7 early write dropped", out_valid, 0);

    // R4/R5/R2: 10 bytes, order 0, ends with two bytes
    configure(0, 10);
    send(32'h44332211);
    send(32'h88776655);
    send(32'hCCBBAA99);
    drop();
    repeat (2) @(negedge clk);
    // R8: write after end of message
    send(32'h12345678);
    drop();
    #2;
    check(wr_err == 1'b1, "R8 late write flags error", wr_err, 1);
    check(out_valid == 1'b0, "R8 late write dropped", out_valid, 0);

    // R10/R2: burst of 4 with order 1
    configure(1, 16);
    send(32'h03020100);
    c0 = acc_cyc;
    send(32'h07060504);
    send(32'h0B0A0908);
    send(32'h0F0E0D0C);
    check(acc_cyc - c0 == 3, "R10 burst in consecutive cycles", 64'(acc_cyc - c0), 3);
    drop();

    // R3: orders 2 and 3, 7-byte messages
    configure(2, 7);
    send(32'hA3A2A1A0);
    send(32'hB3B2B1B0);
    drop();
    configure(3, 7);
    send(32'hC3C2C1C0);
    send(32'hD3D2D1D0);
    drop();

    // R9: backpressure
    configure(0, 8);
    @(negedge clk);
    out_ready = 1'b0;
    send(32'h5A5B5C5D);
    @(negedge clk);
    wr_data = 32'h6A6B6C6D;
    wr_valid = 1'b1;
    #2;
    held = out_data;
    push_exp(32'h6A6B6C6D);
    for (int i = 0; i < 3; i++) begin
      check(wr_ready == 1'b0, "R9 write port stalled", wr_ready, 0);
      check(out_valid == 1'b1 && out_data == held, "R9 output held", out_data, held);
      @(negedge clk); #2;
    end
    @(negedge clk);
    out_ready = 1'b1;
    #2;
    check(wr_ready == 1'b1, "R9 stall released", wr_ready, 1);
    @(posedge clk);
    drop();

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R4 all expected words delivered", 64'(expq.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule